// File: doc/BRIEF.md
# Root Port INTx Event Queue Controller

This block collects legacy level interrupts from the four downstream INTx lines of a bridge root port and presents them to software through a small set of 32-bit registers. Each line is edge-detected. A rising edge becomes an "assert" event and a falling edge becomes a "deassert" event. Each event is encoded as a word and placed in a ring FIFO. Software reads the word at the head of the FIFO and pops it by writing either FIFO read register.

A pending bit for INTx is set whenever an event is accepted. While the FIFO holds anything, the pending bit is held at 1. A mask register selects which pending bits drive the single level-sensitive interrupt output. A status register reports whether the FIFO is empty and whether an event was lost to overflow. It also holds a bridge-enable bit that is driven out of the block. A read-only PHY register reports the link-up strap.

The register bus is a simple one-cycle write strobe with combinational read data. Reads have no side effects.

Top module: `intx_event_ctrl`

## Requirements
- R1: After reset, the decode register (0x138) and the mask register (0x13C) read 0. The status register (0x148) reads 0x0004_0000, which is the empty flag alone. `irq_o` and `bridge_en_o` are 0.
- R2: When line n changes level at a clock edge, an entry is enqueued in that same edge. A rising edge produces word bit31=1, bits 28:27=n, bit29=1. A falling edge produces the same word with bit29=0.
- R3: When several lines change on the same edge, their events are enqueued in ascending line number.
- R4: The FIFO has 16 slots, so at most 15 entries are held. An event that arrives when no slot is free is discarded, and status bit 19 is set. Status bit 19 stays set until software writes 1 to bit 19 of the status register. Free space is judged before any pop in the same cycle.
- R5: Status bit 18 reads 1 when the FIFO is empty and 0 when it holds entries.
- R6: A read of 0x158 returns the head entry's word, or 0 when the FIFO is empty. A read never removes the entry. A read of 0x15C always returns 0.
- R7: A write of any value to 0x158 or 0x15C pops one entry. When the FIFO is empty, such a write has no effect.
- R8: A write to the decode register clears pending bit 16 if bit 16 of the write data is 1. However, bit 16 reads 1 whenever the FIFO is not empty. Bit 16 is also set by every accepted event.
- R9: `irq_o` is 1 exactly when the decode value ANDed with the mask value is nonzero. The mask register is read/write over all 32 bits.
- R10: Status bit 0 is a read/write bridge-enable bit, and it drives `bridge_en_o`. Bit 11 of the PHY register (0x144) follows `link_up_i`. All other PHY bits are 0.
- R11: A read of any other address returns 0. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| intx_i | input | 4 | Downstream INTx levels, synchronous to clk_i |
| link_up_i | input | 1 | Link-up strap |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Level interrupt output |
| bridge_en_o | output | 1 | Bridge-enable control bit |

## Verification
The hardest state to reach from the ports is a completely full ring that then receives more events. Reaching it takes sixteen or more line transitions without any pop in between. The bench gets there by toggling one line twenty times, then drains the FIFO and checks that exactly the first fifteen words come out in order. It also sweeps every pair of 4-bit line patterns, so that every combination of simultaneous rising and falling edges is checked for ascending line order.

// File: rtl/intx_ctrl_pkg.sv
package intx_ctrl_pkg;
  localparam logic [11:0] OFF_DECODE = 12'h138;
  localparam logic [11:0] OFF_MASK   = 12'h13C;
  localparam logic [11:0] OFF_PHY    = 12'h144;
  localparam logic [11:0] OFF_STAT   = 12'h148;
  localparam logic [11:0] OFF_HEAD1  = 12'h158;
  localparam logic [11:0] OFF_HEAD2  = 12'h15C;

  localparam int BIT_BREN  = 0;
  localparam int BIT_LINK  = 11;
  localparam int BIT_INTX  = 16;
  localparam int BIT_EMPTY = 18;
  localparam int BIT_OVF   = 19;
  localparam int POS_LINE  = 27;
  localparam int POS_LVL   = 29;
  localparam int POS_VLD   = 31;
  localparam int LINE_W    = 2;

  function automatic logic [31:0] pack_word(logic [LINE_W-1:0] line, logic lvl);
    logic [31:0] w;
    w = '0;
    w[POS_VLD] = 1'b1;
    w[POS_LVL] = lvl;
    w[POS_LINE +: LINE_W] = line;
    return w;
  endfunction
endpackage

// File: rtl/intx_edge_detect.sv
module intx_edge_detect #(
  parameter int LINES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] lines_i,
  output logic [LINES-1:0] chg_o
);
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lines_i;
  end

  assign chg_o = lines_i ^ prev_q;
endmodule

// File: rtl/intx_event_fifo.sv
module intx_event_fifo #(
  parameter int DEPTH = 16,
  parameter int LINES = 4,
  parameter int EW    = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [LINES-1:0]          push_v_i,
  input  logic [LINES-1:0][EW-1:0]  push_d_i,
  input  logic                      pop_i,
  output logic [EW-1:0]             head_o,
  output logic [AW-1:0]             cnt_o,
  output logic                      any_acc_o,
  output logic                      drop_o
);
  logic [EW-1:0]           mem [DEPTH];
  logic [AW-1:0]           wr_q, rd_q;
  logic [AW:0]             free_s, run_s, nacc_s;
  logic [LINES-1:0]        acc_s;
  logic [LINES-1:0][AW-1:0] slot_s;

  assign cnt_o  = wr_q - rd_q;
  assign free_s = (AW+1)'(DEPTH-1) - {1'b0, cnt_o};

  // rank each push among this cycle's pushes; later lines lose on lack of space
  always_comb begin
    run_s  = '0;
    nacc_s = '0;
    for (int i = 0; i < LINES; i++) begin
      acc_s[i]  = push_v_i[i] && (run_s < free_s);
      slot_s[i] = wr_q + run_s[AW-1:0];
      if (push_v_i[i]) run_s  = run_s + 1'b1;
      if (acc_s[i])    nacc_s = nacc_s + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_q + nacc_s[AW-1:0];
      if (pop_i && cnt_o != '0) rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < LINES; i++)
      if (acc_s[i]) mem[slot_s[i]] <= push_d_i[i];
  end

  assign head_o    = mem[rd_q];
  assign any_acc_o = |acc_s;
  assign drop_o    = |(push_v_i & ~acc_s);
endmodule

// File: rtl/intx_event_ctrl.sv
module intx_event_ctrl
  import intx_ctrl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LINES = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int EW   = LINE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINES-1:0]  intx_i,
  input  logic              link_up_i,
  input  logic              reg_we_i,
  input  logic [11:0]       reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              bridge_en_o
);
  logic [LINES-1:0]         evt_v;
  logic [LINES-1:0][EW-1:0] evt_d;
  logic [EW-1:0]            head;
  logic [AW-1:0]            fifo_cnt;
  logic                     any_acc, drop, pop, fifo_empty;
  logic                     pend_q, ovf_q, bren_q;
  logic [31:0]              mask_q, pend_vec;

  intx_edge_detect #(.LINES(LINES)) u_edge (
    .clk_i, .rst_ni, .lines_i(intx_i), .chg_o(evt_v)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_enc
    assign evt_d[g] = {LINE_W'(g), intx_i[g]};
  end

  assign pop = reg_we_i && (reg_addr_i == OFF_HEAD1 || reg_addr_i == OFF_HEAD2);

  intx_event_fifo #(.DEPTH(DEPTH), .LINES(LINES), .EW(EW)) u_fifo (
    .clk_i, .rst_ni,
    .push_v_i(evt_v), .push_d_i(evt_d), .pop_i(pop),
    .head_o(head), .cnt_o(fifo_cnt), .any_acc_o(any_acc), .drop_o(drop)
  );

  assign fifo_empty = (fifo_cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      mask_q <= '0;
      ovf_q  <= 1'b0;
      bren_q <= 1'b0;
    end else begin
      if (any_acc)
        pend_q <= 1'b1;
      else if (reg_we_i && reg_addr_i == OFF_DECODE && reg_wdata_i[BIT_INTX])
        pend_q <= 1'b0;
      if (reg_we_i && reg_addr_i == OFF_MASK) mask_q <= reg_wdata_i;
      if (drop)
        ovf_q <= 1'b1;
      else if (reg_we_i && reg_addr_i == OFF_STAT && reg_wdata_i[BIT_OVF])
        ovf_q <= 1'b0;
      if (reg_we_i && reg_addr_i == OFF_STAT) bren_q <= reg_wdata_i[BIT_BREN];
    end
  end

  // pending INTx is forced while entries remain queued
  always_comb begin
    pend_vec = '0;
    pend_vec[BIT_INTX] = pend_q | ~fifo_empty;
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_DECODE: reg_rdata_o = pend_vec;
      OFF_MASK:   reg_rdata_o = mask_q;
      OFF_PHY:    reg_rdata_o[BIT_LINK] = link_up_i;
      OFF_STAT: begin
        reg_rdata_o[BIT_BREN]  = bren_q;
        reg_rdata_o[BIT_EMPTY] = fifo_empty;
        reg_rdata_o[BIT_OVF]   = ovf_q;
      end
      OFF_HEAD1:  reg_rdata_o = fifo_empty ? '0 : pack_word(head[EW-1:1], head[0]);
      default:    reg_rdata_o = '0;
    endcase
  end

  assign irq_o       = |(pend_vec & mask_q);
  assign bridge_en_o = bren_q;
endmodule

// File: rtl/intx_event_ctrl_chk.sv
module intx_event_ctrl_chk
  import intx_ctrl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LINES = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             reg_we_i,
  input logic [11:0]      reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic [AW-1:0]    fifo_cnt,
  input logic [LINES-1:0] evt_v,
  input logic             ovf_q
);
  a_r9_mask_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFF_MASK && reg_wdata_i == '0) |=> !irq_o);

  a_r4_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(reg_we_i && reg_addr_i == OFF_STAT && reg_wdata_i[BIT_OVF])) |=> ovf_q);

  a_r4_capacity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt == AW'(DEPTH-1) && evt_v != '0) |=> ovf_q);

  a_r7_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt == '0 && evt_v == '0) |=> fifo_cnt == '0);

  a_r2_push_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt == '0 && evt_v != '0) |=> fifo_cnt != '0);
endmodule

bind intx_event_ctrl intx_event_ctrl_chk #(.DEPTH(DEPTH), .LINES(LINES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .fifo_cnt(fifo_cnt),
  .evt_v(evt_v), .ovf_q(ovf_q)
);

// File: tb/intx_event_ctrl_bench.sv
`timescale 1ns/1ps
module intx_event_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  intx = '0;
  logic        link_up = 1'b1;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, bren;

  int n_chk = 0, n_bad = 0;
  int q[$];
  logic [3:0] lines_m = '0;
  logic pend_m = 0, ovf_m = 0, bren_m = 0;
  logic [31:0] mask_m = '0;

  always #10 clk = ~clk;

  intx_event_ctrl u_intx_event_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .intx_i(intx), .link_up_i(link_up),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .bridge_en_o(bren)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    we = 1'b0;
  endtask

  task automatic set_lines(input logic [3:0] v);
    @(negedge clk);
    intx = v;
    for (int i = 0; i < 4; i++) begin
      if (v[i] != lines_m[i]) begin
        if (q.size() < 15) begin
          q.push_back(32'h8000_0000 | (i << 27) | (int'(v[i]) << 29));
          pend_m = 1'b1;
        end else ovf_m = 1'b1;
      end
    end
    lines_m = v;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] exp_stat();
    return (32'(ovf_m) << 19) | (32'(q.size() == 0) << 18) | 32'(bren_m);
  endfunction

  function automatic logic [31:0] exp_dec();
    return 32'(pend_m | (q.size() != 0)) << 16;
  endfunction

  task automatic chk_state(input string tag);
    logic [31:0] d;
    rd(12'h148, d); chk({tag, " R5 status"}, d, exp_stat());
    rd(12'h138, d); chk({tag, " R8 decode"}, d, exp_dec());
    chk({tag, " R9 irq"}, 32'(irq), 32'(|(exp_dec() & mask_m)));
  endtask

  task automatic drain(input string tag);
    logic [31:0] d;
    while (q.size() != 0) begin
      rd(12'h158, d); chk({tag, " R2 R3 head"}, d, q[0]);
      rd(12'h158, d); chk({tag, " R6 reread"}, d, q[0]);
      rd(12'h15C, d); chk({tag, " R6 word2"}, d, 32'h0);
      wr((q.size() % 2) ? 12'h158 : 12'h15C, 32'hFFFF_FFFF);
      void'(q.pop_front());
    end
    rd(12'h158, d); chk({tag, " R6 empty read"}, d, 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    #35 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    rd(12'h138, d); chk("R1 decode", d, 32'h0);
    rd(12'h13C, d); chk("R1 mask", d, 32'h0);
    rd(12'h148, d); chk("R1 status", d, 32'h0004_0000);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 bridge_en", 32'(bren), 32'h0);
    // R10 bridge enable and link
    rd(12'h144, d); chk("R10 link up", d, 32'h0000_0800);
    link_up = 1'b0;
    rd(12'h144, d); chk("R10 link down", d, 32'h0);
    wr(12'h148, 32'h0000_0001); bren_m = 1'b1;
    chk("R10 bridge_en out", 32'(bren), 32'h1);
    rd(12'h148, d); chk("R10 status bit0", d, exp_stat());
    // R11 unmapped
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, d); chk("R11 unmapped read", d, 32'h0);
    rd(12'h13C, d); chk("R11 mask untouched", d, 32'h0);
    rd(12'h148, d); chk("R11 status untouched", d, exp_stat());
    // R7 pop on empty
    wr(12'h158, 32'h1); wr(12'h15C, 32'h1);
    chk_state("R7 pop empty");
    // R9 mask write readback
    wr(12'h13C, 32'h0001_0000); mask_m = 32'h0001_0000;
    rd(12'h13C, d); chk("R9 mask readback", d, mask_m);
    // R2 R3 sweep over all line pattern pairs
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        set_lines(4'(a));
        set_lines(4'(b));
        chk_state("R2 sweep");
        if (q.size() != 0) begin
          wr(12'h138, 32'h0001_0000); pend_m = 1'b0;
          chk_state("R8 clear while queued");
        end
        drain("R3 sweep");
        chk_state("R8 after drain");
        wr(12'h138, 32'h0001_0000); pend_m = 1'b0;
        chk_state("R8 cleared");
      end
    end
    // R4 overflow
    for (int k = 0; k < 20; k++) set_lines(lines_m ^ 4'b0100);
    chk("R4 ovf flagged", 32'(ovf_m), 32'h1);
    chk_state("R4 full");
    wr(12'h13C, 32'h0); mask_m = '0;
    chk("R9 masked off", 32'(irq), 32'h0);
    wr(12'h13C, 32'h0001_0000); mask_m = 32'h0001_0000;
    drain("R4 drain");
    chk_state("R4 sticky after drain");
    wr(12'h158, 32'h0);
    chk_state("R7 pop empty again");
    wr(12'h148, 32'h0008_0001); ovf_m = 1'b0;
    chk_state("R4 w1c clear");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule